// File: doc/BRIEF.md
# Match Timer

A 32-bit up-counting timer with a small register file on a single-cycle bus. A prescaler divides the clock so that the counter advances once every (prescale + 1) cycles while it is enabled. One compare register is checked against the counter. When they agree, a three-bit match control field picks any mix of three actions: raise an interrupt flag, return the counter to zero, or stop the counter by clearing its enable. A control bit can hold both the counter and the prescaler at zero.

Software uses the block in three ways. With no match action the counter runs freely and acts as a time base. With the interrupt and zero-on-match actions it produces a periodic tick. With all three actions it acts as a one-shot that fires once and then halts. The interrupt output is a level. It stays high while the match flag is set and falls one cycle after software writes 1 to the flag.

Reads on the bus are combinational and need no clock edge. Writes take effect at the clock edge that samples them.

Top module: `match_timer`

## Requirements
- R1: After reset every register reads zero and `irq` is low.
- R2: Register offsets are as follows. Match flag is at 0x00 (bit 0). Control is at 0x04 (bit 0 enable, bit 1 hold-at-zero). Counter is at 0x08. Prescale is at 0x0C. Match control is at 0x14 (bit 0 interrupt, bit 1 zero, bit 2 stop). Compare value is at 0x18. Count mode is at 0x70 and reads back all 32 bits as written. Bits that are not implemented read zero. Any other offset reads zero and ignores writes.
- R3: With prescale value P and enable set, the counter advances once every P+1 clock cycles. With P = 0 it advances every cycle.
- R4: While control bit 1 is set, the counter and prescaler stay at zero and counter writes are ignored. While enable is 0, the counter keeps its value.
- R5: With match control 0, the counter runs freely, wraps from 0xFFFFFFFF to 0, and never sets the flag.
- R6: Suppose the counter holds the compare value at a tick where it would advance and match-control bit 0 is set. Then flag bit 0 is set, and `irq` equals flag bit 0. If match-control bit 0 is clear, no flag is set.
- R7: Writing 1 to flag bit 0 clears it, and `irq` is low after that edge. Writing 0 leaves the flag unchanged. If a match sets the flag on the same edge as a clear write, the flag stays set.
- R8: With match-control bit 1 set, the counter goes to 0 at the match tick instead of incrementing. The period is therefore the compare value plus one ticks.
- R9: With match-control bit 2 set, the match tick clears control bit 0. With bit 1 also clear, the counter stays at the compare value. With bit 1 set it stays at 0, which gives one-shot operation.
- R10: The counter can be written at offset 0x08 and read at any time without disturbing the count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_en | input | 1 | Bus access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational, zero when `bus_en` is low |
| irq | output | 1 | Level interrupt, high while the match flag is set |

## Verification
The hardest case to reach from the ports is a match that sets the flag on the same edge that a software clear-write lands. The flag must survive that edge. The bench reaches this case by starting the counter from a known edge with no prescaling and a compare value of 3. It then idles exactly three cycles, so its next write, a clear, is sampled on the match tick. The stop and one-shot cases are checked after extra idle cycles, which shows that the halted counter really stays frozen.

// File: rtl/mtmr_pkg.sv
package mtmr_pkg;
  // byte offsets of the register file
  localparam int OFF_FLAG = 'h00;
  localparam int OFF_CTRL = 'h04;
  localparam int OFF_CNT  = 'h08;
  localparam int OFF_PRE  = 'h0C;
  localparam int OFF_MC   = 'h14;
  localparam int OFF_CMP  = 'h18;
  localparam int OFF_MODE = 'h70;

  // control bit positions
  localparam int CTRL_EN   = 0;
  localparam int CTRL_HOLD = 1;

  // match action field, bit 2 stop, bit 1 zero, bit 0 interrupt
  typedef struct packed {
    logic stop;
    logic zero;
    logic intr;
  } match_act_t;
endpackage

// File: rtl/mtmr_rst_sync.sv
module mtmr_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/mtmr_prescale.sv
module mtmr_prescale #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             hold,
  input  logic [CNT_W-1:0] pre_val,
  output logic             tick
);
  logic [CNT_W-1:0] pc_q, pc_d;
  logic             at_end;

  assign at_end = (pc_q >= pre_val);
  assign tick   = run && !hold && at_end;

  always_comb begin
    pc_d = pc_q;
    if (hold)                pc_d = '0;
    else if (run && at_end)  pc_d = '0;
    else if (run)            pc_d = pc_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc_q <= '0;
    else        pc_q <= pc_d;
  end

  // R4
  pre_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> (pc_q == '0));
endmodule

// File: rtl/mtmr_core.sv
module mtmr_core
  import mtmr_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             hold,
  input  logic             wr,
  input  logic [CNT_W-1:0] wdata,
  input  logic [CNT_W-1:0] cmp_val,
  input  match_act_t       act,
  output logic [CNT_W-1:0] cnt,
  output logic             match_evt
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign match_evt = tick && !hold && !wr && (cnt_q == cmp_val);
  assign cnt       = cnt_q;

  always_comb begin
    cnt_d = cnt_q;
    if (hold)                         cnt_d = '0;
    else if (wr)                      cnt_d = wdata;
    else if (match_evt && act.zero)   cnt_d = '0;
    else if (match_evt && act.stop)   cnt_d = cnt_q;
    else if (tick)                    cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R8
  zero_on_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (match_evt && act.zero) |=> (cnt_q == '0));

  // R5
  wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !wr && !match_evt && (cnt_q == '1)) |=> (cnt_q == '0));
endmodule

// File: rtl/mtmr_regs.sv
module mtmr_regs
  import mtmr_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata,
  input  logic [CNT_W-1:0]  cnt_val,
  input  logic              match_evt,
  output logic              cnt_en,
  output logic              cnt_hold,
  output logic              cnt_wr,
  output logic              ctrl_wr,
  output logic [CNT_W-1:0]  pre_val,
  output logic [CNT_W-1:0]  cmp_val,
  output match_act_t        act,
  output logic              flag
);
  logic             flag_q, flag_d;
  logic [1:0]       ctrl_q, ctrl_d;
  logic [CNT_W-1:0] pre_q, pre_d;
  logic [CNT_W-1:0] cmp_q, cmp_d;
  logic [CNT_W-1:0] mode_q, mode_d;
  match_act_t       act_q, act_d;
  logic             wr_any;
  logic             sel_flag, sel_pre, sel_mc, sel_cmp, sel_mode;

  assign wr_any   = bus_en && bus_we;
  assign sel_flag = wr_any && (bus_addr == ADDR_W'(OFF_FLAG));
  assign ctrl_wr  = wr_any && (bus_addr == ADDR_W'(OFF_CTRL));
  assign cnt_wr   = wr_any && (bus_addr == ADDR_W'(OFF_CNT));
  assign sel_pre  = wr_any && (bus_addr == ADDR_W'(OFF_PRE));
  assign sel_mc   = wr_any && (bus_addr == ADDR_W'(OFF_MC));
  assign sel_cmp  = wr_any && (bus_addr == ADDR_W'(OFF_CMP));
  assign sel_mode = wr_any && (bus_addr == ADDR_W'(OFF_MODE));

  always_comb begin
    flag_d = flag_q;
    if (sel_flag && bus_wdata[0])     flag_d = 1'b0;
    if (match_evt && act_q.intr)      flag_d = 1'b1;

    ctrl_d = ctrl_q;
    if (match_evt && act_q.stop)      ctrl_d[CTRL_EN] = 1'b0;
    if (ctrl_wr)                      ctrl_d = bus_wdata[1:0];

    pre_d  = sel_pre  ? bus_wdata : pre_q;
    cmp_d  = sel_cmp  ? bus_wdata : cmp_q;
    mode_d = sel_mode ? bus_wdata : mode_q;
    act_d  = sel_mc   ? match_act_t'(bus_wdata[2:0]) : act_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      ctrl_q <= '0;
      pre_q  <= '0;
      cmp_q  <= '0;
      mode_q <= '0;
      act_q  <= '0;
    end else begin
      flag_q <= flag_d;
      ctrl_q <= ctrl_d;
      pre_q  <= pre_d;
      cmp_q  <= cmp_d;
      mode_q <= mode_d;
      act_q  <= act_d;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_en && !bus_we) begin
      case (bus_addr)
        ADDR_W'(OFF_FLAG): bus_rdata[0]   = flag_q;
        ADDR_W'(OFF_CTRL): bus_rdata[1:0] = ctrl_q;
        ADDR_W'(OFF_CNT):  bus_rdata      = cnt_val;
        ADDR_W'(OFF_PRE):  bus_rdata      = pre_q;
        ADDR_W'(OFF_MC):   bus_rdata[2:0] = act_q;
        ADDR_W'(OFF_CMP):  bus_rdata      = cmp_q;
        ADDR_W'(OFF_MODE): bus_rdata      = mode_q;
        default:           bus_rdata      = '0;
      endcase
    end
  end

  assign cnt_en   = ctrl_q[CTRL_EN];
  assign cnt_hold = ctrl_q[CTRL_HOLD];
  assign pre_val  = pre_q;
  assign cmp_val  = cmp_q;
  assign act      = act_q;
  assign flag     = flag_q;

  // R7
  flag_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag_q) |-> $past(sel_flag && bus_wdata[0]));

  // R6
  flag_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(match_evt && act_q.intr));
endmodule

// File: rtl/match_timer.sv
module match_timer
  import mtmr_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata,
  output logic              irq
);
  logic             rst_sync_n;
  logic             cnt_en, cnt_hold, cnt_wr, ctrl_wr;
  logic             tick, match_evt, run;
  logic [CNT_W-1:0] pre_val, cmp_val, cnt_val;
  match_act_t       act;

  assign run = cnt_en && !cnt_hold;

  mtmr_rst_sync rst_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  mtmr_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) regs_i (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .bus_en    (bus_en),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .cnt_val   (cnt_val),
    .match_evt (match_evt),
    .cnt_en    (cnt_en),
    .cnt_hold  (cnt_hold),
    .cnt_wr    (cnt_wr),
    .ctrl_wr   (ctrl_wr),
    .pre_val   (pre_val),
    .cmp_val   (cmp_val),
    .act       (act),
    .flag      (irq)
  );

  mtmr_prescale #(.CNT_W(CNT_W)) pre_i (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .run     (run),
    .hold    (cnt_hold),
    .pre_val (pre_val),
    .tick    (tick)
  );

  mtmr_core #(.CNT_W(CNT_W)) core_i (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .tick      (tick),
    .hold      (cnt_hold),
    .wr        (cnt_wr),
    .wdata     (bus_wdata),
    .cmp_val   (cmp_val),
    .act       (act),
    .cnt       (cnt_val),
    .match_evt (match_evt)
  );

  // R9
  stop_clears_en_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (match_evt && act.stop && !ctrl_wr) |=> !cnt_en);

  // R4
  freeze_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!cnt_en && !cnt_hold && !cnt_wr) |=> $stable(cnt_val));
endmodule

// File: tb/match_timer_tb_top.sv
module match_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_en, bus_we;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        irq;
  int          n_chk = 0;
  int          n_fail = 0;
  bit          done = 0;

  always #4 clk = ~clk;

  match_timer dut_i (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1;
    d = bus_rdata;
    bus_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    logic [7:0] offs [8] = '{8'h00, 8'h04, 8'h08, 8'h0C, 8'h14, 8'h18, 8'h70, 8'h10};
    foreach (offs[i]) begin
      rd(offs[i], v);
      check("R1 reset value", v, 32'h0);
    end
    check("R1 irq after reset", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_regmap;
    logic [31:0] v;
    wr(8'h70, 32'h1234_5678); rd(8'h70, v); check("R2 mode readback", v, 32'h1234_5678);
    wr(8'h18, 32'hDEAD_BEEF); rd(8'h18, v); check("R2 compare readback", v, 32'hDEAD_BEEF);
    wr(8'h0C, 32'h0000_00A5); rd(8'h0C, v); check("R2 prescale readback", v, 32'h0000_00A5);
    wr(8'h14, 32'hFFFF_FFF8); rd(8'h14, v); check("R2 match ctrl unimpl bits", v, 32'h0);
    wr(8'h04, 32'hFFFF_FFFC); rd(8'h04, v); check("R2 control unimpl bits", v, 32'h0);
    wr(8'h10, 32'hFFFF_FFFF); rd(8'h10, v); check("R2 unmapped offset", v, 32'h0);
    rd(8'h0C, v); check("R2 unmapped write no side effect", v, 32'h0000_00A5);
    wr(8'h70, 0); wr(8'h18, 0); wr(8'h0C, 0);
  endtask

  task automatic t_hold;
    logic [31:0] v;
    wr(8'h04, 32'h2); wr(8'h08, 32'd123);
    rd(8'h08, v); check("R4 counter write ignored in hold", v, 32'h0);
    wr(8'h04, 32'h3); idle(5);
    rd(8'h08, v); check("R4 held at zero while enabled", v, 32'h0);
    wr(8'h04, 32'h0); wr(8'h08, 32'd77);
    rd(8'h08, v); check("R10 counter write", v, 32'd77);
    idle(4);
    rd(8'h08, v); check("R4 frozen while disabled", v, 32'd77);
  endtask

  task automatic t_prescale(input int p, input int n1, input int n2);
    logic [31:0] v;
    wr(8'h04, 32'h2); wr(8'h0C, p); wr(8'h04, 32'h1);
    idle(n1);
    rd(8'h08, v); check("R3 prescaled count", v, n1 / (p + 1));
    idle(n2);
    rd(8'h08, v); check("R10 count undisturbed by read", v, (n1 + n2) / (p + 1));
    wr(8'h04, 32'h2); wr(8'h0C, 0);
  endtask

  task automatic t_wrap;
    logic [31:0] v;
    wr(8'h04, 0); wr(8'h14, 0); wr(8'h08, 32'hFFFF_FFFE); wr(8'h04, 32'h1);
    rd(8'h08, v); check("R5 start value", v, 32'hFFFF_FFFE);
    idle(1); rd(8'h08, v); check("R5 top value", v, 32'hFFFF_FFFF);
    idle(1); rd(8'h08, v); check("R5 wrap to zero", v, 32'h0);
    idle(1); rd(8'h08, v); check("R5 after wrap", v, 32'h1);
    rd(8'h00, v); check("R5 no flag in free run", v, 32'h0);
    wr(8'h04, 32'h2);
  endtask

  task automatic t_period;
    logic [31:0] v;
    wr(8'h04, 32'h2); wr(8'h18, 32'd4); wr(8'h14, 32'h3); wr(8'h04, 32'h1);
    idle(4);
    rd(8'h08, v); check("R8 at compare value", v, 32'd4);
    check("R6 no irq before match tick", {31'b0, irq}, 32'h0);
    idle(1);
    rd(8'h08, v); check("R8 zero after match", v, 32'h0);
    rd(8'h00, v); check("R6 flag set on match", v, 32'h1);
    check("R6 irq follows flag", {31'b0, irq}, 32'h1);
    idle(5);
    rd(8'h08, v); check("R8 period is compare plus one", v, 32'h0);
    wr(8'h00, 32'h1);
    check("R7 irq low after clear", {31'b0, irq}, 32'h0);
    wr(8'h04, 32'h2); wr(8'h14, 32'h2); wr(8'h04, 32'h1);
    idle(10);
    rd(8'h00, v); check("R6 no flag without interrupt action", v, 32'h0);
    rd(8'h08, v); check("R8 zero-only period", v, 32'h0);
    wr(8'h04, 32'h2);
  endtask

  task automatic t_stop;
    logic [31:0] v;
    wr(8'h04, 32'h2); wr(8'h00, 32'h1); wr(8'h18, 32'd5); wr(8'h14, 32'h5); wr(8'h04, 32'h1);
    idle(6);
    rd(8'h08, v); check("R9 stopped at compare value", v, 32'd5);
    rd(8'h04, v); check("R9 enable cleared", v, 32'h0);
    check("R6 irq on stop match", {31'b0, irq}, 32'h1);
    idle(4);
    rd(8'h08, v); check("R9 stays stopped", v, 32'd5);
    wr(8'h00, 32'h0);
    check("R7 write zero keeps flag", {31'b0, irq}, 32'h1);
    wr(8'h00, 32'h1);
    check("R7 write one clears flag", {31'b0, irq}, 32'h0);
    wr(8'h04, 32'h2); wr(8'h18, 32'd3); wr(8'h14, 32'h7); wr(8'h04, 32'h1);
    idle(4);
    rd(8'h08, v); check("R9 one-shot back to zero", v, 32'h0);
    rd(8'h04, v); check("R9 one-shot enable cleared", v, 32'h0);
    idle(3);
    rd(8'h08, v); check("R9 one-shot stays at zero", v, 32'h0);
    check("R6 one-shot irq", {31'b0, irq}, 32'h1);
  endtask

  task automatic t_coincide;
    logic [31:0] v;
    wr(8'h04, 32'h2); wr(8'h00, 32'h1); wr(8'h0C, 0);
    wr(8'h18, 32'd3); wr(8'h14, 32'h3); wr(8'h04, 32'h1);
    idle(3);
    wr(8'h00, 32'h1);
    check("R7 set wins over clear", {31'b0, irq}, 32'h1);
    rd(8'h08, v); check("R8 zero at coincident match", v, 32'h0);
    wr(8'h04, 32'h2);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bus_en = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    idle(4);
    rst_n = 1'b1;
    idle(4);
    t_reset;
    t_regmap;
    t_hold;
    t_prescale(0, 7, 3);
    t_prescale(3, 10, 6);
    t_prescale(2, 9, 9);
    t_wrap;
    t_period;
    t_stop;
    t_coincide;
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule